// File: doc/BRIEF.md
# Sixteen-Bit Netlist Dataflow Evaluator

This block evaluates a small combinational netlist held as data. Software loads a table of gate entries. Each entry gives an operation, one or two operands, a constant shift count and the index of the wire it drives. An operand is either a reference to another wire or a literal constant. Entries may sit in the table in any order. A gate may appear before the gates that feed it.

After a start pulse, the engine sweeps the table over and over. It fires a gate only once every operand it needs holds a valid value, writes the 16-bit result into the wire store and marks that wire valid. It reports completion when every gate in the table is retired. It reports an error when a whole sweep retires nothing, so a netlist with a loop or a missing driver cannot hang it.

An override start clears every wire, preloads one chosen wire with a forced value and resolves the netlist again. The gate that normally drives that wire leaves the forced value in place. Any wire's value and valid flag can be read back through a registered read port.

Top module: `netlist_eval`

## Requirements
- R1: Opcodes on `ld_op` are 0 pass-through, 1 bitwise AND, 2 bitwise OR, 3 shift left, 4 logical shift right and 5 bitwise NOT. With x=123 and y=456 the results are AND 72, OR 507, x shifted left by 2 gives 492, y shifted right by 2 gives 114, NOT x gives 65412 and NOT y gives 65079.
- R2: A left shift keeps only the low 16 bits of its result. A right shift fills with zeros. NOT returns 65535 minus its input.
- R3: When an operand's literal flag is 1, its 16-bit field is used as a constant that is always valid. When the flag is 0, the low bits of the field select a wire.
- R4: A gate fires only when all of the operands it uses are valid. Entries may be loaded in any order, and every reachable wire still ends with the correct value.
- R5: When every gate in the first `gate_num` entries is retired, `done` is high for exactly one cycle. `busy` is low in that same cycle, and the block is then idle.
- R6: If a full sweep retires no gate while gates remain, `error` is high for exactly one cycle and the block returns to idle. Wires on the loop stay invalid, and wires resolved before the error keep their values.
- R7: A start with `ovr_en` high clears all wires and sets `ovr_wire` to `ovr_val` as valid. That value is never overwritten by its driver. All other gates resolve using it.
- R8: Every start clears the valid flag of every wire, so a wire with no driver in the current table reads back invalid.
- R9: The read port returns the value and valid flag of `rd_wire` one clock after the wire index is presented.
- R10: Table loads and start pulses presented while `busy` is high are ignored.
- R11: A start with `gate_num` equal to 0 gives a one-cycle `done` at once, with all wires cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one gate entry (only while idle) |
| ld_addr | input | 6 | Gate table entry index |
| ld_op | input | 3 | Operation code (see R1) |
| ld_a_lit | input | 1 | Operand A is a literal |
| ld_a | input | 16 | Operand A literal or wire index |
| ld_b_lit | input | 1 | Operand B is a literal |
| ld_b | input | 16 | Operand B literal or wire index |
| ld_sh | input | 4 | Constant shift count |
| ld_dst | input | 8 | Destination wire index |
| start | input | 1 | Begin a resolution run |
| gate_num | input | 7 | Number of table entries used, counted from entry 0 |
| ovr_en | input | 1 | Start in override mode |
| ovr_wire | input | 8 | Wire forced in override mode |
| ovr_val | input | 16 | Forced value |
| rd_wire | input | 8 | Wire index to read |
| rd_val | output | 16 | Value of the wire read |
| rd_valid | output | 1 | Valid flag of the wire read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle no-progress pulse |

## Verification
Some properties are checked on every cycle. `done` and `error` must each last a single cycle and never occur together. A completion must coincide with every table entry being retired. A firing gate must see its wire operands valid. No wire already valid may be written again, which guards the forced value and the single-driver rule. The arithmetic results, the handling of out-of-order tables, the detection of loops, the override re-resolution and the ignoring of loads during a run can only be shown by the bench scenarios, which read the wires back through the read port.

// File: rtl/nle_pkg.sv
package nle_pkg;
  localparam int DATA_W = 16;
  localparam int SH_W   = 4;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_AND  = 3'd1,
    OP_OR   = 3'd2,
    OP_SHL  = 3'd3,
    OP_SHR  = 3'd4,
    OP_NOT  = 3'd5
  } nle_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EVAL  = 2'd2
  } nle_state_e;
endpackage

// File: rtl/nle_alu.sv
module nle_alu
  import nle_pkg::*;
(
  input  nle_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SH_W-1:0]   sh,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_PASS: y = a;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_SHL:  y = a << sh;
      OP_SHR:  y = a >> sh;
      OP_NOT:  y = ~a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/nle_gate_table.sv
module nle_gate_table #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 48,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nle_wire_store.sv
module nle_wire_store #(
  parameter int NWIRE = 256,
  parameter int DW    = 16,
  localparam int AW = $clog2(NWIRE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] a_idx,
  output logic [DW-1:0] a_val,
  output logic          a_vld,
  input  logic [AW-1:0] b_idx,
  output logic [DW-1:0] b_val,
  output logic          b_vld,
  input  logic [AW-1:0] d_idx,
  output logic          d_vld,
  input  logic [AW-1:0] h_idx,
  output logic [DW-1:0] h_val,
  output logic          h_vld
);
  logic [DW-1:0]    mem [NWIRE];
  logic [NWIRE-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    h_val <= mem[h_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      h_vld <= 1'b0;
    end else begin
      if (clr) vld <= '0;
      if (we)  vld[widx] <= 1'b1;
      h_vld <= vld[h_idx];
    end
  end

  assign a_val = mem[a_idx];
  assign a_vld = vld[a_idx];
  assign b_val = mem[b_idx];
  assign b_vld = vld[b_idx];
  assign d_vld = vld[d_idx];

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |-> !vld[widx]); // R7
endmodule

// File: rtl/netlist_eval.sv
module netlist_eval
  import nle_pkg::*;
#(
  parameter int NGATE = 64,
  parameter int NWIRE = 256,
  localparam int GA_W    = $clog2(NGATE),
  localparam int WA_W    = $clog2(NWIRE),
  localparam int CNT_W   = GA_W + 1,
  localparam int ENTRY_W = 3 + 1 + DATA_W + 1 + DATA_W + SH_W + WA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [GA_W-1:0]   ld_addr,
  input  logic [2:0]        ld_op,
  input  logic              ld_a_lit,
  input  logic [DATA_W-1:0] ld_a,
  input  logic              ld_b_lit,
  input  logic [DATA_W-1:0] ld_b,
  input  logic [SH_W-1:0]   ld_sh,
  input  logic [WA_W-1:0]   ld_dst,
  input  logic              start,
  input  logic [CNT_W-1:0]  gate_num,
  input  logic              ovr_en,
  input  logic [WA_W-1:0]   ovr_wire,
  input  logic [DATA_W-1:0] ovr_val,
  input  logic [WA_W-1:0]   rd_wire,
  output logic [DATA_W-1:0] rd_val,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              error
);
  nle_state_e        state;
  logic [GA_W-1:0]   idx;
  logic [CNT_W-1:0]  num_q;
  logic [CNT_W-1:0]  rcnt;
  logic [NGATE-1:0]  resolved;
  logic              progress;
  logic              done_q, err_q;

  // gate table
  logic [ENTRY_W-1:0] tbl_rdata;
  logic               tbl_we;

  assign tbl_we = ld_en && (state == ST_IDLE);

  nle_gate_table #(.DEPTH(NGATE), .WIDTH(ENTRY_W)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (ld_addr),
    .wdata ({ld_op, ld_a_lit, ld_a, ld_b_lit, ld_b, ld_sh, ld_dst}),
    .raddr (idx),
    .rdata (tbl_rdata)
  );

  // entry decode
  logic [2:0]        e_op_raw;
  logic              e_a_lit, e_b_lit;
  logic [DATA_W-1:0] e_a, e_b;
  logic [SH_W-1:0]   e_sh;
  logic [WA_W-1:0]   e_dst;
  nle_op_e           e_op;

  assign {e_op_raw, e_a_lit, e_a, e_b_lit, e_b, e_sh, e_dst} = tbl_rdata;
  assign e_op = nle_op_e'(e_op_raw);

  // wire store
  logic              st_clr, st_we;
  logic [WA_W-1:0]   st_widx;
  logic [DATA_W-1:0] st_wdata;
  logic [DATA_W-1:0] a_val, b_val;
  logic              a_vld, b_vld, dst_vld;
  logic              idle_start;

  assign idle_start = start && (state == ST_IDLE);

  nle_wire_store #(.NWIRE(NWIRE), .DW(DATA_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .clr   (st_clr),
    .we    (st_we),
    .widx  (st_widx),
    .wdata (st_wdata),
    .a_idx (e_a[WA_W-1:0]),
    .a_val (a_val),
    .a_vld (a_vld),
    .b_idx (e_b[WA_W-1:0]),
    .b_val (b_val),
    .b_vld (b_vld),
    .d_idx (e_dst),
    .d_vld (dst_vld),
    .h_idx (rd_wire),
    .h_val (rd_val),
    .h_vld (rd_valid)
  );

  // operand selection and evaluation
  logic [DATA_W-1:0] opa, opb, alu_y;
  logic              need_b, a_ok, b_ok, in_eval, skip, retire, fire, last_gate;
  logic [CNT_W-1:0]  next_cnt;
  logic              next_prog;

  assign opa    = e_a_lit ? e_a : a_val;
  assign opb    = e_b_lit ? e_b : b_val;
  assign need_b = (e_op == OP_AND) || (e_op == OP_OR);
  assign a_ok   = e_a_lit || a_vld;
  assign b_ok   = !need_b || e_b_lit || b_vld;

  nle_alu u_alu (
    .op (e_op),
    .a  (opa),
    .b  (opb),
    .sh (e_sh),
    .y  (alu_y)
  );

  assign in_eval   = (state == ST_EVAL);
  assign skip      = resolved[idx];
  // a gate whose destination already holds a value (forced) retires without writing
  assign retire    = in_eval && !skip && (dst_vld || (a_ok && b_ok));
  assign fire      = in_eval && !skip && !dst_vld && a_ok && b_ok;
  assign last_gate = ({1'b0, idx} == (num_q - 1'b1));
  assign next_cnt  = rcnt + {{(CNT_W-1){1'b0}}, retire};
  assign next_prog = progress || retire;

  assign st_clr   = idle_start;
  assign st_we    = (idle_start && ovr_en) || fire;
  assign st_widx  = in_eval ? e_dst : ovr_wire;
  assign st_wdata = in_eval ? alu_y : ovr_val;

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      num_q    <= '0;
      rcnt     <= '0;
      resolved <= '0;
      progress <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            idx      <= '0;
            num_q    <= gate_num;
            rcnt     <= '0;
            resolved <= '0;
            progress <= 1'b0;
            if (gate_num == '0) done_q <= 1'b1;
            else                state  <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_EVAL;
        ST_EVAL: begin
          if (retire) resolved[idx] <= 1'b1;
          rcnt <= next_cnt;
          if (last_gate) begin
            if (next_cnt == num_q) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else if (!next_prog) begin
              err_q <= 1'b1;
              state <= ST_IDLE;
            end else begin
              idx      <= '0;
              progress <= 1'b0;
              state    <= ST_FETCH;
            end
          end else begin
            idx      <= idx + 1'b1;
            progress <= next_prog;
            state    <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = done_q;
  assign error = err_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_DONE_ALL_RETIRED: assert property (@(posedge clk) disable iff (rst)
    done |-> (rcnt == num_q)); // R5
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    error |=> !error); // R6
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && error)); // R6
  AST_FIRE_OPERANDS_READY: assert property (@(posedge clk) disable iff (rst)
    (in_eval && st_we) |-> ((e_a_lit || a_vld) && (!need_b || e_b_lit || b_vld))); // R4
endmodule

// File: tb/netlist_eval_tb_top.sv
module netlist_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [2:0]  ld_op = '0;
  logic        ld_a_lit = 1'b0;
  logic [15:0] ld_a = '0;
  logic        ld_b_lit = 1'b0;
  logic [15:0] ld_b = '0;
  logic [3:0]  ld_sh = '0;
  logic [7:0]  ld_dst = '0;
  logic        start = 1'b0;
  logic [6:0]  gate_num = '0;
  logic        ovr_en = 1'b0;
  logic [7:0]  ovr_wire = '0;
  logic [15:0] ovr_val = '0;
  logic [7:0]  rd_wire = '0;
  logic [15:0] rd_val;
  logic        rd_valid, busy, done, error;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  netlist_eval dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_op(ld_op),
    .ld_a_lit(ld_a_lit), .ld_a(ld_a), .ld_b_lit(ld_b_lit), .ld_b(ld_b),
    .ld_sh(ld_sh), .ld_dst(ld_dst), .start(start), .gate_num(gate_num),
    .ovr_en(ovr_en), .ovr_wire(ovr_wire), .ovr_val(ovr_val),
    .rd_wire(rd_wire), .rd_val(rd_val), .rd_valid(rd_valid),
    .busy(busy), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(input int addr, input int op, input bit al, input int a,
                      input bit bl, input int b, input int sh, input int dst);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 6'(addr); ld_op = 3'(op);
    ld_a_lit = al; ld_a = 16'(a); ld_b_lit = bl; ld_b = 16'(b);
    ld_sh = 4'(sh); ld_dst = 8'(dst);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // returns 1 = done, 2 = error, 0 = timeout; on a pulse also checks its width
  task automatic wait_end(output int res);
    res = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done || error) begin
        res = done ? 1 : 2;
        chk(!busy, "R5 busy low with end pulse", busy, 0);
        @(negedge clk);
        chk(!done && !error && !busy, "R5/R6 single-cycle end pulse",
            {done, error, busy}, 0);
        return;
      end
      @(negedge clk);
    end
    chk(1'b0, "end of run timeout", 0, 1);
  endtask

  task automatic run(input int num, input bit ovr, input int w, input int v, output int res);
    @(negedge clk);
    start = 1'b1; gate_num = 7'(num); ovr_en = ovr; ovr_wire = 8'(w); ovr_val = 16'(v);
    @(negedge clk);
    start = 1'b0; ovr_en = 1'b0;
    wait_end(res);
  endtask

  task automatic rd(input int w, output int val, output bit vld);
    @(negedge clk);
    rd_wire = 8'(w);
    @(negedge clk);
    val = int'(rd_val); vld = rd_valid;
  endtask

  task automatic expect_wire(input int w, input int exp, input string tag);
    int v; bit ok;
    rd(w, v, ok);
    chk(ok, {tag, " valid"}, ok, 1);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic expect_invalid(input int w, input string tag);
    int v; bit ok;
    rd(w, v, ok);
    chk(!ok, tag, ok, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !error, "reset outputs idle", {busy, done, error}, 0);
    expect_invalid(0, "R9 reset wire invalid");
  endtask

  // example netlist loaded in reverse dependency order
  task automatic t_basic_ops;
    int r;
    load(0, 5, 0, 1, 1, 0, 0, 7);
    load(1, 5, 0, 0, 1, 0, 0, 6);
    load(2, 4, 0, 1, 1, 0, 2, 5);
    load(3, 3, 0, 0, 1, 0, 2, 4);
    load(4, 2, 0, 0, 0, 1, 0, 3);
    load(5, 1, 0, 0, 0, 1, 0, 2);
    load(6, 0, 1, 456, 1, 0, 0, 1);
    load(7, 0, 1, 123, 1, 0, 0, 0);
    run(8, 0, 0, 0, r);
    chk(r == 1, "R4 run completes", r, 1);
    expect_wire(2, 72, "R1 AND");
    expect_wire(3, 507, "R1 OR");
    expect_wire(4, 492, "R1 SHL");
    expect_wire(5, 114, "R1 SHR");
    expect_wire(6, 65412, "R1 NOT x");
    expect_wire(7, 65079, "R1 NOT y");
    expect_wire(0, 123, "R9 read x");
  endtask

  task automatic t_edges;
    int r;
    load(0, 0, 1, 16'h8001, 1, 0, 0, 10);
    load(1, 3, 0, 10, 1, 0, 1, 11);
    load(2, 4, 0, 10, 1, 0, 15, 12);
    load(3, 5, 1, 0, 1, 0, 0, 13);
    load(4, 1, 0, 10, 1, 16'h00FF, 0, 14);
    load(5, 2, 1, 16'h1000, 1, 16'h0234, 0, 15);
    run(6, 0, 0, 0, r);
    chk(r == 1, "R2 run completes", r, 1);
    expect_wire(11, 2, "R2 SHL truncation");
    expect_wire(12, 1, "R2 SHR zero fill");
    expect_wire(13, 65535, "R2 NOT of zero");
    expect_wire(14, 1, "R3 AND with literal");
    expect_wire(15, 16'h1234, "R3 both literal");
    expect_invalid(0, "R8 old wire cleared");
  endtask

  task automatic t_chain;
    int r;
    load(0, 5, 0, 21, 1, 0, 0, 22);
    load(1, 3, 0, 20, 1, 0, 1, 21);
    load(2, 0, 1, 5, 1, 0, 0, 20);
    run(3, 0, 0, 0, r);
    chk(r == 1, "R4 chain completes", r, 1);
    expect_wire(20, 5, "R4 chain head");
    expect_wire(21, 10, "R4 chain mid");
    expect_wire(22, 65525, "R4 chain tail");
  endtask

  task automatic t_loop;
    int r;
    load(0, 0, 0, 31, 1, 0, 0, 30);
    load(1, 0, 0, 30, 1, 0, 0, 31);
    load(2, 0, 1, 7, 1, 0, 0, 32);
    run(3, 0, 0, 0, r);
    chk(r == 2, "R6 loop reports error", r, 2);
    expect_invalid(30, "R6 loop wire invalid");
    expect_wire(32, 7, "R6 resolved wire kept");
  endtask

  task automatic t_override;
    int r;
    load(0, 0, 1, 3, 1, 0, 0, 40);
    load(1, 3, 0, 40, 1, 0, 2, 41);
    run(2, 0, 0, 0, r);
    chk(r == 1, "R7 first pass completes", r, 1);
    expect_wire(41, 12, "R7 first pass result");
    run(2, 1, 40, 12, r);
    chk(r == 1, "R7 override completes", r, 1);
    expect_wire(40, 12, "R7 forced wire kept");
    expect_wire(41, 48, "R7 re-resolved result");
    expect_invalid(32, "R8 unrelated wire cleared");
  endtask

  task automatic t_busy_ignore;
    int r;
    @(negedge clk);
    start = 1'b1; gate_num = 7'd2;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R10 busy after start", busy, 1);
    ld_en = 1'b1; ld_addr = 6'd1; ld_op = 3'd0; ld_a_lit = 1'b1; ld_a = 16'd999;
    ld_b_lit = 1'b1; ld_b = '0; ld_sh = '0; ld_dst = 8'd41;
    start = 1'b1; gate_num = 7'd0;
    @(negedge clk);
    ld_en = 1'b0; start = 1'b0;
    wait_end(r);
    chk(r == 1, "R10 run completes", r, 1);
    expect_wire(41, 12, "R10 load during busy ignored");
    run(2, 0, 0, 0, r);
    expect_wire(41, 12, "R10 table unchanged on rerun");
  endtask

  task automatic t_empty;
    int r;
    run(0, 0, 0, 0, r);
    chk(r == 1, "R11 empty table done", r, 1);
    expect_invalid(41, "R11 wires cleared");
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_ops();
    t_edges();
    t_chain();
    t_loop();
    t_override();
    t_busy_ignore();
    t_empty();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule